// File: doc/BRIEF.md
# Dual-Port PS/2 Host Controller

This block is the host side of two independent PS/2 links. Each port drives its clock and data wires in open-drain style and watches both lines. The attached device generates the clock. Either port takes a keyboard or a mouse, because the two ports behave the same and the block does not interpret the bytes it moves. Bytes from a device are framed and checked, then queued in a per-port receive FIFO deep enough for the host to collect them late. A byte written by the host goes out with the host-to-device request sequence: the clock is inhibited, the data line is pulled low, the bits are shifted out, and the device's acknowledge bit is checked at the end.

The processor side is an 8-bit register window. Address bit 2 selects the port. Address bits 1:0 select data, status or configuration. The configuration register holds four interrupt enables and the power switch for that port. When a port is switched off, its receive queue and any frame in progress are discarded, so a device can be unplugged and plugged in again safely. Timeouts on a stalled clock return a port to idle, so a device removed in the middle of a frame does not hang the link.

Top module: `ps2_dual_host`

## Requirements
- R1: After reset, every status and configuration register of both ports reads 0x00, and `ps2_clk_oe_o`, `ps2_dat_oe_o`, `pwr_en_o` and `irq_o` are all 0.
- R2: A device frame has a start bit 0, eight data bits least significant first, an odd parity bit and a stop bit 1, with the data line sampled on each falling device clock edge. Such a frame is queued in that port's FIFO, and status bit 0 then reads 1. Reads at offset 0 return the bytes in arrival order, and each read pops one byte.
- R3: A frame whose parity is even, or whose stop bit is 0, sets status bit 3 and is discarded, so status bit 0 stays 0.
- R4: The FIFO holds FIFO_DEPTH bytes, and status bit 6 reads 1 when it is full. A byte that completes while the FIFO is full is dropped and sets status bit 4, and the bytes already queued are kept.
- R5: A write at offset 0 of an idle, powered port drives the clock low for at least INHIBIT_CYC cycles. The block then pulls data low and releases the clock. It sends the eight data bits least significant first, then odd parity, then a released stop bit, changing data on falling device clock edges.
- R6: A transmit that ends with the data line low at the eleventh falling edge sets status bit 1. If the line is high there, status bit 7 is set and bit 1 is not.
- R7: During a frame, a gap longer than BIT_TO_CYC between falling edges sets status bit 2 and returns the port to idle. The same happens if no edge arrives within REQ_TO_CYC after a transmit request. In both cases status bit 5 reads 0, both lines are released, and a later frame is received correctly.
- R8: Configuration bits 3:0 enable interrupts for status bits 3:0 (received data waiting, transmit done, timeout, frame error). `irq_o` is the OR over both ports of these enabled conditions.
- R9: Configuration bit 4 drives that port's `pwr_en_o` bit. Clearing it flushes the FIFO, aborts any frame in progress and releases both lines within one cycle. While the port is off, device activity on it is ignored.
- R10: Traffic on one port never changes the other port's status.
- R11: Writing to offset 1 clears each of status bits 1, 2, 3, 4 and 7 for which the written byte has a 1. Bits written as 0 keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address: bit 2 selects the port, bits 1:0 select 0 data, 1 status, 2 configuration |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; at offset 0 it pops the FIFO |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed register, combinational |
| irq_o | output | 1 | Interrupt request |
| ps2_clk_i | input | 2 | Per-port clock line level |
| ps2_dat_i | input | 2 | Per-port data line level |
| ps2_clk_oe_o | output | 2 | Per-port clock pull-down enable (1 drives the line low) |
| ps2_dat_oe_o | output | 2 | Per-port data pull-down enable (1 drives the line low) |
| pwr_en_o | output | 2 | Per-port device power enable |

## Verification
The bench models a device on each wire and sweeps byte values across both ports in each direction. It checks every received and transmitted bit against parity computed in the bench, so a design with the bit order reversed or even parity fails at once. It fills a shortened FIFO past its depth and checks that the oldest bytes survive, which catches a design that overwrites the head or loses the overflow flag. It cuts frames short, leaves transmit requests unanswered and drops power in the middle of an inhibit. A design that does not recover would leave the port busy or a line held low. It also measures the inhibit length and the data level when the clock is released, which a design that releases the clock too early would fail.

// File: rtl/ps2_pkg.sv
`timescale 1ns/1ps
package ps2_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_INH,
    ST_STRT,
    ST_REQ,
    ST_TXB,
    ST_ACK
  } port_st_e;

  localparam int unsigned NPORT = 2;
endpackage

// File: rtl/ps2_filt.sv
`timescale 1ns/1ps
module ps2_filt #(
  parameter int unsigned DEB_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic fall_o
);
  localparam int unsigned CW = $clog2(DEB_CYC + 1);

  logic          s0_q, s1_q, lvl_q;
  logic [CW-1:0] cnt_q;
  logic          upd;

  assign upd    = (s1_q != lvl_q) && (cnt_q == CW'(DEB_CYC - 1));
  assign fall_o = upd && lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_q  <= 1'b1;
      s1_q  <= 1'b1;
      lvl_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      s0_q <= line_i;
      s1_q <= s0_q;
      if (s1_q == lvl_q) begin
        cnt_q <= '0;
      end else if (upd) begin
        lvl_q <= s1_q;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ps2_fifo.sv
`timescale 1ns/1ps
module ps2_fifo #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned NW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [NW-1:0] n_q;
  logic          do_wr, do_rd;

  assign empty_o = (n_q == '0);
  assign full_o  = (n_q == NW'(DEPTH));
  assign do_wr   = wr_i && !full_o;
  assign do_rd   = rd_i && !empty_o;
  assign rdata_o = empty_o ? '0 : mem[rp_q];

  always_ff @(posedge clk_i) begin
    if (do_wr) mem[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
      n_q  <= '0;
    end else if (flush_i) begin
      wp_q <= '0;
      rp_q <= '0;
      n_q  <= '0;
    end else begin
      if (do_wr) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_rd) rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      if (do_wr && !do_rd)      n_q <= n_q + 1'b1;
      else if (do_rd && !do_wr) n_q <= n_q - 1'b1;
    end
  end
endmodule

// File: rtl/ps2_port.sv
`timescale 1ns/1ps
module ps2_port
  import ps2_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH  = 256,
  parameter int unsigned INHIBIT_CYC = 5000,
  parameter int unsigned BIT_TO_CYC  = 100000,
  parameter int unsigned REQ_TO_CYC  = 750000,
  parameter int unsigned DEB_CYC     = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_i,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  input  logic       tx_stb_i,
  input  logic [7:0] tx_byte_i,
  input  logic       pop_i,
  input  logic [7:0] clr_i,
  output logic       ps2_clk_oe_o,
  output logic       ps2_dat_oe_o,
  output logic [7:0] status_o,
  output logic [7:0] rx_byte_o
);
  localparam int unsigned TM1  = (BIT_TO_CYC > INHIBIT_CYC) ? BIT_TO_CYC : INHIBIT_CYC;
  localparam int unsigned TMAX = (REQ_TO_CYC > TM1) ? REQ_TO_CYC : TM1;
  localparam int unsigned TW   = $clog2(TMAX + 1);

  port_st_e      st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [3:0]    bit_q, bit_d;
  logic [8:0]    rx_sh_q, rx_sh_d;
  logic [9:0]    tx_sh_q, tx_sh_d;
  logic          dlow_q, dlow_d;
  logic          dat_m_q, dat_s_q;
  logic          fall;
  logic          push, ev_done, ev_nack, ev_to, ev_par, ev_ovf;
  logic          done_q, nack_q, to_q, par_q, ovf_q;
  logic          empty, full;
  logic          bit_to, req_to;

  ps2_filt #(.DEB_CYC(DEB_CYC)) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (ps2_clk_i),
    .fall_o (fall)
  );

  ps2_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (!pwr_i),
    .wr_i    (push && !full),
    .wdata_i (rx_sh_q[7:0]),
    .rd_i    (pop_i),
    .rdata_o (rx_byte_o),
    .empty_o (empty),
    .full_o  (full)
  );

  assign bit_to = (tmr_q == TW'(BIT_TO_CYC - 1));
  assign req_to = (tmr_q == TW'(REQ_TO_CYC - 1));
  assign ev_ovf = push && full;

  always_comb begin
    st_d    = st_q;
    tmr_d   = tmr_q + 1'b1;
    bit_d   = bit_q;
    rx_sh_d = rx_sh_q;
    tx_sh_d = tx_sh_q;
    dlow_d  = dlow_q;
    push    = 1'b0;
    ev_done = 1'b0;
    ev_nack = 1'b0;
    ev_to   = 1'b0;
    ev_par  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        tmr_d  = '0;
        dlow_d = 1'b0;
        if (tx_stb_i) begin
          st_d    = ST_INH;
          tx_sh_d = {1'b1, ~^tx_byte_i, tx_byte_i};
        end else if (fall && !dat_s_q) begin
          st_d  = ST_RX;
          bit_d = '0;
        end
      end
      ST_RX: begin
        if (fall) begin
          tmr_d = '0;
          if (bit_q == 4'd9) begin
            st_d = ST_IDLE;
            if (dat_s_q && ^rx_sh_q) push = 1'b1;
            else                     ev_par = 1'b1;
          end else begin
            rx_sh_d = {dat_s_q, rx_sh_q[8:1]};
            bit_d   = bit_q + 1'b1;
          end
        end else if (bit_to) begin
          ev_to = 1'b1;
          st_d  = ST_IDLE;
        end
      end
      ST_INH: begin
        if (tmr_q == TW'(INHIBIT_CYC - 1)) begin
          st_d   = ST_STRT;
          dlow_d = 1'b1;
          tmr_d  = '0;
        end
      end
      ST_STRT: begin
        st_d  = ST_REQ;
        tmr_d = '0;
      end
      ST_REQ, ST_TXB: begin
        if (fall) begin
          tmr_d   = '0;
          dlow_d  = ~tx_sh_q[0];
          tx_sh_d = {1'b0, tx_sh_q[9:1]};
          if (st_q == ST_REQ) begin
            bit_d = 4'd1;
            st_d  = ST_TXB;
          end else begin
            bit_d = bit_q + 1'b1;
            if (bit_q == 4'd9) st_d = ST_ACK;
          end
        end else if ((st_q == ST_REQ) ? req_to : bit_to) begin
          ev_to  = 1'b1;
          st_d   = ST_IDLE;
          dlow_d = 1'b0;
        end
      end
      ST_ACK: begin
        dlow_d = 1'b0;
        if (fall) begin
          st_d = ST_IDLE;
          if (!dat_s_q) ev_done = 1'b1;
          else          ev_nack = 1'b1;
        end else if (bit_to) begin
          ev_to = 1'b1;
          st_d  = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (!pwr_i) begin
      st_d    = ST_IDLE;
      dlow_d  = 1'b0;
      push    = 1'b0;
      ev_done = 1'b0;
      ev_nack = 1'b0;
      ev_to   = 1'b0;
      ev_par  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      tmr_q   <= '0;
      bit_q   <= '0;
      rx_sh_q <= '0;
      tx_sh_q <= '0;
      dlow_q  <= 1'b0;
      dat_m_q <= 1'b1;
      dat_s_q <= 1'b1;
      done_q  <= 1'b0;
      nack_q  <= 1'b0;
      to_q    <= 1'b0;
      par_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      tmr_q   <= tmr_d;
      bit_q   <= bit_d;
      rx_sh_q <= rx_sh_d;
      tx_sh_q <= tx_sh_d;
      dlow_q  <= dlow_d;
      dat_m_q <= ps2_dat_i;
      dat_s_q <= dat_m_q;
      // set wins over a same-cycle clear
      done_q  <= (done_q & ~clr_i[1]) | ev_done;
      to_q    <= (to_q   & ~clr_i[2]) | ev_to;
      par_q   <= (par_q  & ~clr_i[3]) | ev_par;
      ovf_q   <= (ovf_q  & ~clr_i[4]) | ev_ovf;
      nack_q  <= (nack_q & ~clr_i[7]) | ev_nack;
    end
  end

  assign ps2_clk_oe_o = (st_q == ST_INH) || (st_q == ST_STRT);
  assign ps2_dat_oe_o = dlow_q;
  assign status_o     = {nack_q, full, (st_q != ST_IDLE), ovf_q, par_q, to_q, done_q, !empty};
endmodule

// File: rtl/ps2_dual_host.sv
`timescale 1ns/1ps
module ps2_dual_host
  import ps2_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH  = 256,
  parameter int unsigned INHIBIT_CYC = 5000,
  parameter int unsigned BIT_TO_CYC  = 100000,
  parameter int unsigned REQ_TO_CYC  = 750000,
  parameter int unsigned DEB_CYC     = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] addr_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o,
  input  logic [1:0] ps2_clk_i,
  input  logic [1:0] ps2_dat_i,
  output logic [1:0] ps2_clk_oe_o,
  output logic [1:0] ps2_dat_oe_o,
  output logic [1:0] pwr_en_o
);
  localparam logic [1:0] OFF_DATA = 2'd0;
  localparam logic [1:0] OFF_STS  = 2'd1;
  localparam logic [1:0] OFF_CFG  = 2'd2;

  logic [NPORT-1:0][7:0] cfg_q;
  logic [NPORT-1:0][7:0] sts;
  logic [NPORT-1:0][7:0] rxb;
  logic [NPORT-1:0]      irq_p;
  logic [1:0]            off;

  assign off = addr_i[1:0];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic sel;
    assign sel = (addr_i[2] == p[0]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              cfg_q[p] <= '0;
      else if (wr_en_i && sel && off == OFF_CFG) cfg_q[p] <= wdata_i & 8'h1F;
    end

    ps2_port #(
      .FIFO_DEPTH  (FIFO_DEPTH),
      .INHIBIT_CYC (INHIBIT_CYC),
      .BIT_TO_CYC  (BIT_TO_CYC),
      .REQ_TO_CYC  (REQ_TO_CYC),
      .DEB_CYC     (DEB_CYC)
    ) u_port (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .pwr_i        (cfg_q[p][4]),
      .ps2_clk_i    (ps2_clk_i[p]),
      .ps2_dat_i    (ps2_dat_i[p]),
      .tx_stb_i     (wr_en_i && sel && off == OFF_DATA),
      .tx_byte_i    (wdata_i),
      .pop_i        (rd_en_i && sel && off == OFF_DATA),
      .clr_i        ((wr_en_i && sel && off == OFF_STS) ? wdata_i : 8'h00),
      .ps2_clk_oe_o (ps2_clk_oe_o[p]),
      .ps2_dat_oe_o (ps2_dat_oe_o[p]),
      .status_o     (sts[p]),
      .rx_byte_o    (rxb[p])
    );

    // enable bits line up with status bits 3:0
    assign irq_p[p]    = |(cfg_q[p][3:0] & sts[p][3:0]);
    assign pwr_en_o[p] = cfg_q[p][4];
  end

  assign irq_o = |irq_p;

  always_comb begin
    unique case (off)
      OFF_DATA: rdata_o = rxb[addr_i[2]];
      OFF_STS:  rdata_o = sts[addr_i[2]];
      OFF_CFG:  rdata_o = cfg_q[addr_i[2]];
      default:  rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/ps2_dual_host_chk.sv
`timescale 1ns/1ps
module ps2_dual_host_chk #(
  parameter int unsigned INHIBIT_CYC = 5000
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      clk_oe_i,
  input logic [1:0]      dat_oe_i,
  input logic [1:0]      pwr_i,
  input logic            irq_i,
  input logic [1:0][7:0] cfg_i
);
  // R8: no enable bit set, no interrupt
  a_r8_no_enable_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i[0][3:0] == 4'h0 && cfg_i[1][3:0] == 4'h0) |-> !irq_i);

  for (genvar p = 0; p < 2; p++) begin : g_chk
    logic [31:0] inh_cnt;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         inh_cnt <= '0;
      else if (clk_oe_i[p]) inh_cnt <= inh_cnt + 1;
      else                 inh_cnt <= '0;
    end

    // R9: power off releases both lines on the next cycle
    a_r9_off_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pwr_i[p] |=> (!clk_oe_i[p] && !dat_oe_i[p]));

    // R5: clock inhibit lasts at least INHIBIT_CYC cycles
    a_r5_inhibit_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(clk_oe_i[p]) && pwr_i[p]) |-> (inh_cnt >= INHIBIT_CYC));

    // R5: data is already low when the clock is let go
    a_r5_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(clk_oe_i[p]) && pwr_i[p]) |-> dat_oe_i[p]);
  end
endmodule

bind ps2_dual_host ps2_dual_host_chk #(.INHIBIT_CYC(INHIBIT_CYC)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clk_oe_i (ps2_clk_oe_o),
  .dat_oe_i (ps2_dat_oe_o),
  .pwr_i    (pwr_en_o),
  .irq_i    (irq_o),
  .cfg_i    (cfg_q)
);

// File: tb/tb_ps2_dual_host.sv
`timescale 1ns/1ps
module tb_ps2_dual_host;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int INH        = 20;
  localparam int BIT_TO     = 400;
  localparam int REQ_TO     = 1500;
  localparam int HALF       = 20 * CLK_PERIOD;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] addr_i = '0;
  logic       wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o;
  logic [1:0] ps2_clk_i, ps2_dat_i, ps2_clk_oe_o, ps2_dat_oe_o, pwr_en_o;
  logic [1:0] dev_clk_low = '0, dev_dat_low = '0;

  int n_chk = 0, n_fail = 0;

  assign ps2_clk_i = ~(dev_clk_low | ps2_clk_oe_o);
  assign ps2_dat_i = ~(dev_dat_low | ps2_dat_oe_o);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ps2_dual_host #(
    .FIFO_DEPTH(DEPTH), .INHIBIT_CYC(INH), .BIT_TO_CYC(BIT_TO),
    .REQ_TO_CYC(REQ_TO), .DEB_CYC(2)
  ) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, input logic pop, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; rd_en_i = pop;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  function automatic logic [2:0] ra(input int p, input int off);
    return {p[0], off[1:0]};
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // device-to-host frame, nbits of the 11 are sent
  task automatic dev_send(input int p, input logic [7:0] b, input logic bad_par,
                          input logic bad_stop, input int nbits);
    logic [10:0] fr;
    fr = {~bad_stop, (~^b) ^ bad_par, b, 1'b0};
    for (int i = 0; i < nbits; i++) begin
      dev_dat_low[p] = ~fr[i];
      #(HALF) dev_clk_low[p] = 1'b1;
      #(HALF) dev_clk_low[p] = 1'b0;
    end
    dev_dat_low[p] = 1'b0;
    #(HALF);
  endtask

  // host-to-device frame; returns the 10 bits after start and inhibit length
  task automatic dev_recv(input int p, input logic nack, output logic [9:0] bits,
                          output int inh, output logic start_low);
    inh = 0;
    wait (ps2_clk_oe_o[p]);
    while (ps2_clk_oe_o[p]) begin
      @(posedge clk_i);
      inh++;
    end
    @(negedge clk_i);
    start_low = ps2_dat_oe_o[p];
    for (int k = 1; k <= 11; k++) begin
      if (k == 11) dev_dat_low[p] = ~nack;
      #(HALF) dev_clk_low[p] = 1'b1;
      #(HALF) dev_clk_low[p] = 1'b0;
      if (k <= 10) bits[k-1] = ps2_dat_i[p];
    end
    #(HALF) dev_dat_low[p] = 1'b0;
    wait_cyc(10);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    logic [9:0] bits;
    int         inh;
    logic       sl;

    wait_cyc(3);
    rst_ni = 1'b1;
    wait_cyc(2);

    // R1 reset state
    for (int p = 0; p < 2; p++) begin
      reg_rd(ra(p, 1), 1'b0, v); chk("R1 status", v, 8'h00);
      reg_rd(ra(p, 2), 1'b0, v); chk("R1 config", v, 8'h00);
    end
    chk("R1 outputs", {ps2_clk_oe_o, ps2_dat_oe_o, pwr_en_o, irq_o}, 7'd0);

    // R9 power on
    reg_wr(ra(0, 2), 8'h10);
    reg_wr(ra(1, 2), 8'h10);
    chk("R9 pwr_en", pwr_en_o, 2'b11);

    // R2/R10 receive sweep over both ports
    for (int i = 0; i < 16; i++) begin
      logic [7:0] b;
      int p;
      b = 8'(i * 37 + 5);
      p = i % 2;
      dev_send(p, b, 1'b0, 1'b0, 11);
      reg_rd(ra(p, 1), 1'b0, v); chk("R2 rx avail", v & 8'h21, 8'h01);
      reg_rd(ra(1 - p, 1), 1'b0, v); chk("R10 other port", v, 8'h00);
      reg_rd(ra(p, 0), 1'b1, v); chk("R2 rx byte", v, b);
      reg_rd(ra(p, 1), 1'b0, v); chk("R2 popped", v & 8'h01, 8'h00);
    end

    // R4 overflow keeps queued bytes
    for (int i = 0; i <= DEPTH; i++) dev_send(0, 8'(8'hC0 + i), 1'b0, 1'b0, 11);
    reg_rd(ra(0, 1), 1'b0, v); chk("R4 full+ovf", v & 8'h51, 8'h51);
    for (int i = 0; i < DEPTH; i++) begin
      reg_rd(ra(0, 0), 1'b1, v); chk("R4 order", v, 8'(8'hC0 + i));
    end
    reg_rd(ra(0, 1), 1'b0, v); chk("R4 drained", v & 8'h41, 8'h00);
    reg_wr(ra(0, 1), 8'h10);
    reg_rd(ra(0, 1), 1'b0, v); chk("R11 ovf cleared", v, 8'h00);

    // R3 bad parity, then bad stop
    dev_send(1, 8'h5A, 1'b1, 1'b0, 11);
    reg_rd(ra(1, 1), 1'b0, v); chk("R3 parity", v, 8'h08);
    reg_wr(ra(1, 1), 8'h00);
    reg_rd(ra(1, 1), 1'b0, v); chk("R11 zero keeps", v, 8'h08);
    reg_wr(ra(1, 1), 8'h08);
    dev_send(1, 8'h3C, 1'b0, 1'b1, 11);
    reg_rd(ra(1, 1), 1'b0, v); chk("R3 stop", v, 8'h08);
    reg_wr(ra(1, 1), 8'h08);

    // R5/R6 transmit sweep with ack
    for (int i = 0; i < 8; i++) begin
      logic [7:0] b;
      int p;
      b = 8'(i * 53 + 17);
      p = i % 2;
      fork
        dev_recv(p, 1'b0, bits, inh, sl);
        reg_wr(ra(p, 0), b);
      join
      chk("R5 inhibit", (inh >= INH), 1);
      chk("R5 start low", sl, 1'b1);
      chk("R5 data", bits[7:0], b);
      chk("R5 parity", bits[8], ~^b);
      chk("R5 stop", bits[9], 1'b1);
      reg_rd(ra(p, 1), 1'b0, v); chk("R6 ack done", v, 8'h02);
      reg_wr(ra(p, 1), 8'h02);
    end

    // R6 nack
    fork
      dev_recv(0, 1'b1, bits, inh, sl);
      reg_wr(ra(0, 0), 8'h81);
    join
    reg_rd(ra(0, 1), 1'b0, v); chk("R6 nack", v, 8'h80);
    reg_wr(ra(0, 1), 8'h80);

    // R7 truncated frame, then recovery
    dev_send(0, 8'hA7, 1'b0, 1'b0, 4);
    wait_cyc(BIT_TO + 50);
    reg_rd(ra(0, 1), 1'b0, v); chk("R7 rx timeout", v, 8'h04);
    reg_wr(ra(0, 1), 8'h04);
    dev_send(0, 8'h6E, 1'b0, 1'b0, 11);
    reg_rd(ra(0, 0), 1'b1, v); chk("R7 recovered", v, 8'h6E);

    // R7/R8 unanswered request raises a timeout interrupt
    reg_wr(ra(1, 2), 8'h14);
    chk("R8 idle no irq", irq_o, 1'b0);
    reg_wr(ra(1, 0), 8'hEE);
    wait_cyc(INH + REQ_TO + 50);
    reg_rd(ra(1, 1), 1'b0, v); chk("R7 req timeout", v, 8'h04);
    chk("R7 lines free", {ps2_clk_oe_o[1], ps2_dat_oe_o[1]}, 2'b00);
    chk("R8 timeout irq", irq_o, 1'b1);
    reg_wr(ra(1, 1), 8'h04);
    chk("R8 irq cleared", irq_o, 1'b0);

    // R8 receive interrupt on port 0
    reg_wr(ra(0, 2), 8'h11);
    dev_send(0, 8'h12, 1'b0, 1'b0, 11);
    chk("R8 rx irq", irq_o, 1'b1);
    reg_rd(ra(0, 0), 1'b1, v);
    chk("R8 rx irq gone", irq_o, 1'b0);

    // R9 power off flushes and aborts
    dev_send(0, 8'h21, 1'b0, 1'b0, 11);
    dev_send(0, 8'h22, 1'b0, 1'b0, 11);
    reg_wr(ra(0, 0), 8'h33);
    wait_cyc(5);
    chk("R9 inhibit on", ps2_clk_oe_o[0], 1'b1);
    reg_wr(ra(0, 2), 8'h00);
    wait_cyc(2);
    chk("R9 pwr off", pwr_en_o, 2'b10);
    chk("R9 lines free", {ps2_clk_oe_o[0], ps2_dat_oe_o[0]}, 2'b00);
    dev_send(0, 8'h44, 1'b0, 1'b0, 11);
    reg_wr(ra(0, 2), 8'h10);
    reg_rd(ra(0, 1), 1'b0, v); chk("R9 flushed", v, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule